// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Binary Counter

This block is a chain of 4-bit binary up-counter stages. All of them share one clock, one clear, one load strobe and one parallel count enable. Each stage moves on the rising clock edge, and its priority order is:

1. An active-low clear, which acts at once without waiting for the clock.
2. An active-low synchronous load from its slice of the data bus.
3. An increment.
4. Hold.

A stage increments only when both of its count enables are high. These are the shared parallel enable and its own trickle enable. Each stage raises a terminal-count flag when it holds all ones while its trickle enable is high. That flag is the trickle enable of the next stage up. Because the parallel enable goes to every stage directly, the chain counts as one wide synchronous counter with carry look-ahead and no gates between stages.

The number of stages is a parameter. The count bus carries stage 0 in its least significant nibble. A single-stage build is the stand-alone 4-bit counter.

Top module: `sync_count_chain`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros and `tc` is low at once. This holds without a clock edge and regardless of every other input.
- R2: On a rising edge with `load_n` low and `clr_n` high, `q` takes the value of `din`. Stage i loads `din[4i+3:4i]`.
- R3: On a rising edge with `load_n` high and both `en_par` and `en_trk` high, the full `q` value increases by one.
- R4: On a rising edge with `load_n` high and either `en_par` or `en_trk` low, `q` keeps its value.
- R5: An increment from all ones wraps `q` to zero, for a single stage (15 to 0) and for the whole chain alike.
- R6: `tc` is high exactly when every bit of `q` is one and `en_trk` is high. It follows those signals in the same cycle, with no clock edge in between.
- R7: In a chain, a stage above stage 0 advances only on an edge where every stage below it holds 15 and `en_trk` and `en_par` are high. The chain therefore equals a single counter of 4 times STAGES bits.
- R8: A load takes effect even when both count enables are high, so load has priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable, common to all stages |
| en_trk | input | 1 | Trickle count enable into stage 0 |
| din | input | 4*STAGES | Parallel load data, stage 0 in bits 3:0 |
| q | output | 4*STAGES | Count value, stage 0 in bits 3:0 |
| tc | output | 1 | Terminal count of the top stage |

## Verification
The results are due at different times:

- Load, increment, hold and wrap appear on `q` one rising edge after the inputs that select them.
- `tc` is a pure function of the current `q` and `en_trk`, so it is due in the same cycle.
- A clear is due within a fraction of a cycle.

The bench changes inputs just after a falling edge. A behavioural reference updates on the rising edge that follows, and both `q` and `tc` are compared at the next falling edge, so every clocked result is judged exactly one edge after its stimulus. For the asynchronous clear, the bench drops `clr_n` shortly after a rising edge and checks the outputs one nanosecond later, before any further clock edge.

// File: rtl/sync_count_chain.sv
module sync_count_stage (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       load_n,
  input  logic       en_par,
  input  logic       en_trk,
  input  logic [3:0] din,
  output logic [3:0] q,
  output logic       tc
);
  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n)               q <= 4'd0;
    else if (!load_n)         q <= din;
    else if (en_par && en_trk) q <= q + 4'd1;

  assign tc = en_trk && (q == 4'hF);
endmodule

module sync_count_chain #(
  parameter int STAGES = 3,
  localparam int NB = 4 * STAGES
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          en_par,
  input  logic          en_trk,
  input  logic [NB-1:0] din,
  output logic [NB-1:0] q,
  output logic          tc
);
  logic [STAGES:0] carry;

  assign carry[0] = en_trk;
  assign tc       = carry[STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    sync_count_stage u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_par (en_par),
      .en_trk (carry[i]),
      .din    (din[4*i +: 4]),
      .q      (q[4*i +: 4]),
      .tc     (carry[i+1])
    );
  end
endmodule

// File: rtl/sync_count_chain_chk.sv
module sync_count_chain_chk #(
  parameter int NB = 12
) (
  input logic          clk,
  input logic          clr_n,
  input logic          load_n,
  input logic          en_par,
  input logic          en_trk,
  input logic [NB-1:0] din,
  input logic [NB-1:0] q,
  input logic          tc
);
  p_clear_r1: assert property (@(posedge clk)
    !clr_n |-> (q == '0 && !tc));

  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  p_count_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> q == NB'($past(q) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && (&q)) |=> q == '0);

  p_tc_r6: assert property (@(posedge clk) disable iff (!clr_n)
    tc == ((&q) && en_trk));
endmodule

bind sync_count_chain sync_count_chain_chk #(.NB(NB)) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
  .en_trk(en_trk), .din(din), .q(q), .tc(tc)
);

// File: tb/test_sync_count_chain.sv
module test_sync_count_chain;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        clr_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [11:0] din = '0;
  logic [11:0] q3;
  logic [3:0]  q1;
  logic        tc3, tc1;

  sync_count_chain #(.STAGES(3)) i_sync_count_chain (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .q(q3), .tc(tc3));

  sync_count_chain #(.STAGES(1)) i_single (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din[3:0]), .q(q1), .tc(tc1));

  int total = 0, bad = 0;
  int ref3 = 0, ref1 = 0;
  string cur = "R1";

  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin ref3 <= 0; ref1 <= 0; end
    else if (!load_n) begin ref3 <= int'(din); ref1 <= int'(din[3:0]); end
    else if (en_par && en_trk) begin
      ref3 <= (ref3 + 1) % 4096;
      ref1 <= (ref1 + 1) % 16;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(cur, "chain q", int'(q3), ref3);
    chk(cur, "chain tc", int'(tc3), int'(ref3 == 4095 && en_trk));
    chk(cur, "single q", int'(q1), ref1);
    chk(cur, "single tc", int'(tc1), int'(ref1 == 15 && en_trk));
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic set(logic ld, logic ep, logic et, logic [11:0] d);
    load_n = ld; en_par = ep; en_trk = et; din = d;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, with load and enables active
    set(1'b0, 1'b1, 1'b1, 12'hABC);
    cur = "R1"; cyc(3);
    // R3: plain counting
    set(1'b1, 1'b1, 1'b1, 12'h000);
    clr_n = 1'b1;
    cur = "R3"; cyc(20);
    // R4: hold on either enable low
    cur = "R4"; set(1'b1, 1'b0, 1'b1, 12'h000); cyc(5);
    set(1'b1, 1'b1, 1'b0, 12'h000); cyc(5);
    set(1'b1, 1'b0, 1'b0, 12'h000); cyc(3);
    // R2: load with enables low
    cur = "R2"; set(1'b0, 1'b0, 1'b0, 12'h5A3); cyc(1);
    // R8: load with enables high
    cur = "R8"; set(1'b0, 1'b1, 1'b1, 12'h123); cyc(2);
    // R6: tc at all ones, gated by trickle
    cur = "R6"; set(1'b0, 1'b0, 1'b0, 12'hFFF); cyc(1);
    set(1'b1, 1'b0, 1'b1, 12'h000); cyc(2);
    set(1'b1, 1'b0, 1'b0, 12'h000); cyc(2);
    // R5: wrap of whole chain and of the single stage
    cur = "R5"; set(1'b0, 1'b0, 1'b0, 12'hFFC); cyc(1);
    set(1'b1, 1'b1, 1'b1, 12'h000); cyc(8);
    // R7: carry into upper stages only at 15 below
    cur = "R7"; set(1'b0, 1'b0, 1'b0, 12'h0EE); cyc(1);
    set(1'b1, 1'b1, 1'b1, 12'h000); cyc(4);
    set(1'b0, 1'b0, 1'b0, 12'h3FE); cyc(1);
    set(1'b1, 1'b1, 1'b1, 12'h000); cyc(3);
    set(1'b1, 1'b1, 1'b0, 12'h000); cyc(2);
    // R1: clear mid-cycle, no edge needed
    cur = "R1"; set(1'b0, 1'b0, 1'b0, 12'h7FF); cyc(1);
    set(1'b1, 1'b1, 1'b1, 12'h000);
    @(posedge clk); #2;
    clr_n = 1'b0; #1;
    chk("R1", "async chain q", int'(q3), 0);
    chk("R1", "async chain tc", int'(tc3), 0);
    chk("R1", "async single q", int'(q1), 0);
    cyc(2);
    clr_n = 1'b1;
    // R7: mixed random traffic against the reference
    cur = "R7";
    for (int k = 0; k < 3000; k++) begin
      set(($urandom % 16) != 0, ($urandom % 8) != 0, ($urandom % 8) != 0,
          12'(($urandom % 2) ? 32'hFF0 + $urandom % 16 : $urandom));
      cyc(1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule